// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block joins two parallel buses, A and B. Each direction has its own storage register with its own rising-edge clock. Each direction can either pass the opposite bus through live or drive out what it has stored. Each register loads its input bus on every rising edge of its clock, whatever the output enables are doing. A bus can therefore be sampled while it is an input, while it is isolated, or while the block itself is driving it.

The bidirectional pins appear as three separate signals on each side: an external input vector, an output vector, and a drive flag that tells the pad ring when to drive. The enable for the B side is active high. The enable for the A side is active low. When a bus is driven, its effective value is the block's own output. The register on that side captures this effective value, so data from one bus can be stored in both registers.

Top module: `dual_reg_xcvr`

## Requirements
- R1: On every rising edge of `clk_ab`, the A-to-B register loads the effective A value. This is `a_out` when `a_oe` is 1, and `a_in` otherwise. Both enables and both selects are ignored for this capture.
- R2: On every rising edge of `clk_ba`, the B-to-A register loads the effective B value. This is `b_out` when `b_oe` is 1, and `b_in` otherwise. Both enables and both selects are ignored for this capture.
- R3: `b_oe` equals `drive_b_en` (active high). `a_oe` equals the inverse of `drive_a_n` (active low).
- R4: With `drive_b_en`=0 and `drive_a_n`=1 (isolation), both drive flags are 0 and both output vectors are 0. Both registers still capture from `a_in` and `b_in`.
- R5: While B is driven, `sel_ab`=0 puts the live A source on `b_out` with no clock needed. `sel_ab`=1 puts the A-to-B register contents on `b_out`.
- R6: While A is driven, `sel_ba`=0 puts the live B source on `a_out` with no clock needed. `sel_ba`=1 puts the B-to-A register contents on `a_out`.
- R7: With both sides driven and both selects at 1, `b_out` holds the A-to-B register and `a_out` holds the B-to-A register at the same time.
- R8: While B is driven live from A, a `clk_ba` edge loads the A data into the B-to-A register. The mirror case loads the B data into the A-to-B register.
- R9: The live source taken from a side is that side's register when that side is itself driven with select 1. In every other case it is that side's external input. With both sides driven and both selects at 0, `b_out`=`a_in` and `a_out`=`b_in`.
- R10: When `rst` is 1 at a rising edge of a register's clock, that register clears to zero.
- R11: Any output vector whose drive flag is 0 reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst | input | 1 | Synchronous active-high clear, sampled on each register's own clock |
| drive_b_en | input | 1 | Drive B bus, active high |
| drive_a_n | input | 1 | Drive A bus, active low |
| sel_ab | input | 1 | B-side source: 0 live, 1 stored |
| sel_ba | input | 1 | A-side source: 0 live, 1 stored |
| a_in | input | W | Value present on the A pins |
| a_out | output | W | Value the block drives onto A |
| a_oe | output | 1 | Drive flag for the A pins |
| b_in | input | W | Value present on the B pins |
| b_out | output | W | Value the block drives onto B |
| b_oe | output | 1 | Drive flag for the B pins |

## Verification
The bench changes live inputs between clock edges. A design that registered the pass-through path would lag by one edge. The bench also stores into both registers while the B side is driven from A. A design that captured the raw pin input instead of the effective bus value would load stale `b_in` here. It drives both enables with both selects live. A design that resolved this case differently from the cross-connect rule would show the wrong value on both outputs. Enable polarity and the zeroed undriven outputs are swept over every select combination, so a swapped polarity or a leaked mux value shows up at once.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;
endpackage

// File: rtl/xcvr_store_reg.sv
`timescale 1ns/1ps
module xcvr_store_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] data;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) st_d.data = '0;
        else     st_d.data = din;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.data;

    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> dout == '0);
endmodule

// File: rtl/xcvr_dir_path.sv
`timescale 1ns/1ps
module xcvr_dir_path
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         drive,
    input  src_sel_e     sel,
    input  logic [W-1:0] stored,
    input  logic [W-1:0] live,
    output logic [W-1:0] bus_out,
    output logic         bus_oe
);
    logic [W-1:0] picked;

    always_comb begin
        picked = (sel == SRC_STORED) ? stored : live;
        bus_oe = drive;
        bus_out = drive ? picked : '0;
    end
endmodule

// File: rtl/dual_reg_xcvr.sv
`timescale 1ns/1ps
module dual_reg_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         rst,
    input  logic         drive_b_en,
    input  logic         drive_a_n,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    logic         a_drv, b_drv;
    logic [W-1:0] ab_q, ba_q;
    logic [W-1:0] a_live_src, b_live_src;
    logic [W-1:0] a_eff, b_eff;

    assign a_drv = ~drive_a_n;
    assign b_drv = drive_b_en;

    // Live source of a side: its stored value if that side is driven from store,
    // else its external pins. Breaks the loop when both sides pass live.
    assign a_live_src = (a_drv && sel_ba) ? ba_q : a_in;
    assign b_live_src = (b_drv && sel_ab) ? ab_q : b_in;

    xcvr_dir_path #(.W(W)) u_path_to_b (
        .drive   (b_drv),
        .sel     (src_sel_e'(sel_ab)),
        .stored  (ab_q),
        .live    (a_live_src),
        .bus_out (b_out),
        .bus_oe  (b_oe)
    );

    xcvr_dir_path #(.W(W)) u_path_to_a (
        .drive   (a_drv),
        .sel     (src_sel_e'(sel_ba)),
        .stored  (ba_q),
        .live    (b_live_src),
        .bus_out (a_out),
        .bus_oe  (a_oe)
    );

    assign a_eff = a_oe ? a_out : a_in;
    assign b_eff = b_oe ? b_out : b_in;

    xcvr_store_reg #(.W(W)) u_reg_ab (
        .clk  (clk_ab),
        .rst  (rst),
        .din  (a_eff),
        .dout (ab_q)
    );

    xcvr_store_reg #(.W(W)) u_reg_ba (
        .clk  (clk_ba),
        .rst  (rst),
        .din  (b_eff),
        .dout (ba_q)
    );

    a_r1_ab_capture: assert property (@(posedge clk_ab) disable iff (rst)
        !$past(rst) |-> ab_q == $past(a_eff));
    a_r2_ba_capture: assert property (@(posedge clk_ba) disable iff (rst)
        !$past(rst) |-> ba_q == $past(b_eff));
    a_r3_b_enable: assert property (@(posedge clk_ab) disable iff (rst)
        drive_b_en |-> b_oe);
    a_r4_isolation: assert property (@(posedge clk_ab) disable iff (rst)
        (!drive_b_en && drive_a_n) |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));
    a_r5_b_stored: assert property (@(posedge clk_ab) disable iff (rst)
        (drive_b_en && sel_ab) |-> b_out == ab_q);
    a_r6_a_stored: assert property (@(posedge clk_ba) disable iff (rst)
        (!drive_a_n && sel_ba) |-> a_out == ba_q);
    a_r11_idle_zero: assert property (@(posedge clk_ba) disable iff (rst)
        !a_oe |-> a_out == '0);
endmodule

// File: tb/dual_reg_xcvr_tb.sv
`timescale 1ns/1ps
module dual_reg_xcvr_tb_top;
    localparam int W = 8;

    logic clk = 0;
    logic gate_ab = 0, gate_ba = 0;
    logic clk_ab, clk_ba;
    logic rst = 1;
    logic drive_b_en = 0, drive_a_n = 1, sel_ab = 0, sel_ba = 0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic a_oe, b_oe;

    int n_vec = 0, n_bad = 0;
    logic [W-1:0] m_ab = '0, m_ba = '0;
    bit done = 0;

    always #4 clk = ~clk;
    assign clk_ab = clk & gate_ab;
    assign clk_ba = clk & gate_ba;

    dual_reg_xcvr #(.W(W)) dut_i (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst),
        .drive_b_en(drive_b_en), .drive_a_n(drive_a_n),
        .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic chk(input string tag, input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic step(input string tag, input logic pab, input logic pba);
        logic ad, bd, eao, ebo;
        logic [W-1:0] asrc, bsrc, ea, eb, effa, effb, nab, nba;
        @(negedge clk);
        gate_ab = pab;
        gate_ba = pba;
        #1;
        ad = !drive_a_n;
        bd = drive_b_en;
        asrc = (ad && sel_ba) ? m_ba : a_in;
        bsrc = (bd && sel_ab) ? m_ab : b_in;
        eb = '0; ea = '0;
        if (bd) eb = sel_ab ? m_ab : asrc;
        if (ad) ea = sel_ba ? m_ba : bsrc;
        eao = ad; ebo = bd;
        chk(tag, "b_out", b_out, eb);
        chk(tag, "a_out", a_out, ea);
        chk(tag, "b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, ebo});
        chk(tag, "a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, eao});
        effa = ad ? ea : a_in;
        effb = bd ? eb : b_in;
        nab = pab ? (rst ? '0 : effa) : m_ab;
        nba = pba ? (rst ? '0 : effb) : m_ba;
        @(posedge clk);
        #1;
        m_ab = nab;
        m_ba = nba;
    endtask

    task automatic setm(input logic eb, input logic na, input logic sab, input logic sba);
        drive_b_en = eb; drive_a_n = na; sel_ab = sab; sel_ba = sba;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R10: reset both registers while isolated
        a_in = 8'h5A; b_in = 8'hC3;
        setm(0, 1, 0, 0);
        step("R10", 1, 1);
        step("R10", 1, 1);
        rst = 0;
        setm(1, 0, 1, 1);
        step("R10", 0, 0);  // both stored, both registers zero

        // R4 + R1 + R2: isolation, capture still happens
        setm(0, 1, 1, 0);
        a_in = 8'h3C; b_in = 8'h81;
        step("R4", 1, 1);
        step("R11", 0, 0);
        setm(1, 0, 1, 1);
        step("R1", 0, 0);   // b_out=3C, a_out=81 shows captures (R2)

        // R5: live path, changes between edges
        setm(1, 1, 0, 0);
        a_in = 8'h11; b_in = 8'hEE;
        step("R5", 0, 0);
        a_in = 8'h22;
        step("R5", 0, 0);
        a_in = 8'hF0;
        step("R3", 0, 0);

        // R6: A driven live then stored
        setm(0, 0, 0, 0);
        b_in = 8'h47;
        step("R6", 0, 0);
        b_in = 8'h48;
        step("R6", 0, 0);
        setm(0, 0, 0, 1);
        step("R6", 0, 0);

        // R8: B driven live from A, clk_ba stores A data in both
        setm(1, 1, 0, 0);
        a_in = 8'hA7; b_in = 8'h00;
        step("R8", 1, 1);
        setm(1, 0, 1, 1);
        step("R8", 0, 0);   // expect both outputs A7
        // mirror: A driven live from B
        setm(0, 0, 0, 0);
        b_in = 8'h6D; a_in = 8'h00;
        step("R8", 1, 1);
        setm(1, 0, 1, 1);
        step("R7", 0, 0);   // both stored, both 6D

        // R7: distinct stored values both ways
        setm(0, 1, 0, 0);
        a_in = 8'h12; b_in = 8'h34;
        step("R4", 1, 1);
        setm(1, 0, 1, 1);
        a_in = 8'hFF; b_in = 8'hFF;
        step("R7", 0, 0);

        // R9: both driven, both live -> cross connect; mixed cases
        setm(1, 0, 0, 0);
        a_in = 8'h9A; b_in = 8'h5B;
        step("R9", 0, 0);
        step("R9", 1, 1);   // captures effective values
        setm(1, 0, 0, 1);
        step("R9", 0, 0);
        setm(1, 0, 1, 0);
        step("R9", 0, 0);

        // sweep of all combinations
        for (int i = 0; i < 400; i++) begin
            logic [3:0] m;
            m = 4'($urandom);
            setm(m[0], m[1], m[2], m[3]);
            a_in = W'($urandom);
            b_in = W'($urandom);
            step("R3", 1'($urandom), 1'($urandom));
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule